// File: doc/BRIEF.md
# Metering Event Flag Register

This block collects the event flags of a three-phase energy metering datapath and raises one raw interrupt. It watches four pulse-output pins and the sign of the energy each pulse carries. It watches the per-phase active and reactive power values, which it samples on an accumulation-update strobe. It also takes an energy-ready strobe, a corrected-error event and a group of fatal error events. Each event sets a sticky flag. Software reads the flags over a small register bus and clears a flag by writing 1 to its bit.

The pulse pins are asynchronous. Each pin passes through a two-flop synchronizer, and only a high-to-low transition counts as a pulse. Each pulse output and each phase keeps the last sign it saw, so that a reversal flag can compare the current polarity with the previous one. A configuration input selects whether the phase monitors watch total power or fundamental power. Fatal error flags are not maskable. Bus writes never clear them, and only a reset does.

Status word layout at address 0, with default parameters: bits 3:0 are the pulse events of outputs 0..3. Bits 7:4 are the polarity reversals of outputs 0..3. Bits 10:8 are the active-power sign changes of phases A..C, and bits 13:11 are the reactive-power sign changes of phases A..C. Bit 14 is energy ready, bit 15 is the corrected error, and bits 18:16 are the fatal errors. Address 1 holds the interrupt enable, one bit for each of status bits 15:0.

Top module: `mtr_flag_reg`

## Requirements
- R1: After reset every status bit, every enable bit and `irq` are 0, and every remembered sign is positive.
- R2: A pulse flag (bit i, i = 0..3) is set two clock edges after the synchronizer first samples pin i low following a high. A rising edge or a steady level sets nothing.
- R3: At each detected falling edge of pin i, the reversal flag (bit 4+i) is set if `pulse_neg[i]` differs from the sign stored at the previous falling edge of that pin. The stored sign then takes the new value. The first negative pulse after reset therefore sets the flag, and a first positive pulse does not.
- R4: When `pwr_upd` is 1, active flag (bit 8+p) is set if the sign bit (MSB) of phase p's selected active power differs from the stored sign for that phase. The stored sign is then updated. Without the strobe, power values have no effect.
- R5: The reactive flags (bits 13:11) follow the same rule as R4, using the reactive power inputs.
- R6: `sign_sel` = 0 selects the total-power inputs, and `sign_sel` = 1 selects the fundamental-power inputs, for both the active and the reactive monitors.
- R7: `egy_upd` sets the energy-ready flag (bit 14) on the next edge.
- R8: A write to address 0 clears every maskable status bit whose data bit is 1. Data bits of 0 leave their bits unchanged. A set event in the same cycle wins, and the bit stays 1.
- R9: `err_corr` sets bit 15, which clears by writing 1. `err_fatal[k]` sets bit 16+k, which ignores all writes and clears only on reset.
- R10: `irq` is 1 exactly when some status bit 15:0 is 1 together with its enable bit, or when any fatal bit is 1.
- R11: A write to address 1 loads the enable register from data bits 15:0. A read at address 1 returns the enable register, and a read at address 0 returns the status word, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_pin | input | 4 | Asynchronous pulse-output pins |
| pulse_neg | input | 4 | Sign of the energy of each pin's current pulse (1 = negative) |
| pwr_upd | input | 1 | Power accumulation update strobe |
| sign_sel | input | 1 | 0 = monitor total power, 1 = fundamental |
| act_tot | input | 72 | Total active power, phase p at [24p+23:24p], signed |
| act_fund | input | 72 | Fundamental active power, same packing |
| rea_tot | input | 72 | Total reactive power, same packing |
| rea_fund | input | 72 | Fundamental reactive power, same packing |
| egy_upd | input | 1 | Energy registers updated strobe |
| err_fatal | input | 3 | Fatal error events |
| err_corr | input | 1 | Corrected error event |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address (0 status, 1 enable) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Raw interrupt |

## Verification
Directed pulse trains on single pins separate falling-edge detection from rising or steady levels. Repeated same-sign and alternating-sign pulses show whether the reversal memory is kept separately for each output and starts positive. Power values that change sign while the strobe is idle, then under a strobe with `sign_sel` in each position, show whether sampling is gated and whether the correct source is picked. A long random phase mixes pin activity, strobes, errors and clear writes that land in the same cycle as set events. This exercises set-over-clear priority, the fatal bits' immunity to writes and the masking of the interrupt.

// File: rtl/mtr_flag_reg.sv
module mtr_flag_reg #(
  parameter int NP = 4,
  parameter int NF = 3,
  parameter int PW = 24,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   pulse_pin,
  input  logic [NP-1:0]   pulse_neg,
  input  logic            pwr_upd,
  input  logic            sign_sel,
  input  logic [3*PW-1:0] act_tot,
  input  logic [3*PW-1:0] act_fund,
  input  logic [3*PW-1:0] rea_tot,
  input  logic [3*PW-1:0] rea_fund,
  input  logic            egy_upd,
  input  logic [NF-1:0]   err_fatal,
  input  logic            err_corr,
  input  logic            bus_we,
  input  logic            bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq
);
  localparam int NM = 2*NP + 8;
  localparam int SW = NM + NF;

  logic [NP-1:0] s1, s2, s3, fall, pev_q, rev_q, plast_q, rev_set;
  logic [2:0]    asgn, rsgn, alast_q, rlast_q, aflg_q, rflg_q, a_set, r_set;
  logic          egy_q, corr_q;
  logic [NF-1:0] fat_q;
  logic [NM-1:0] en_q;
  logic [DW-1:0] wclr;
  logic [SW-1:0] status;

  assign fall = s3 & ~s2;
  assign wclr = (bus_we && !bus_addr) ? bus_wdata : '0;

  for (genvar p = 0; p < 3; p++) begin : g_ph
    assign asgn[p] = sign_sel ? act_fund[p*PW+PW-1] : act_tot[p*PW+PW-1];
    assign rsgn[p] = sign_sel ? rea_fund[p*PW+PW-1] : rea_tot[p*PW+PW-1];
  end

  assign rev_set = fall & (pulse_neg ^ plast_q);
  assign a_set   = {3{pwr_upd}} & (asgn ^ alast_q);
  assign r_set   = {3{pwr_upd}} & (rsgn ^ rlast_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      pev_q <= '0; rev_q <= '0; plast_q <= '0;
      alast_q <= '0; rlast_q <= '0; aflg_q <= '0; rflg_q <= '0;
      egy_q <= 1'b0; corr_q <= 1'b0; fat_q <= '0; en_q <= '0;
    end else begin
      s1 <= pulse_pin; s2 <= s1; s3 <= s2;
      pev_q   <= (pev_q & ~wclr[NP-1:0]) | fall;
      rev_q   <= (rev_q & ~wclr[2*NP-1:NP]) | rev_set;
      plast_q <= (plast_q & ~fall) | (pulse_neg & fall);
      aflg_q  <= (aflg_q & ~wclr[2*NP+2:2*NP]) | a_set;
      rflg_q  <= (rflg_q & ~wclr[2*NP+5:2*NP+3]) | r_set;
      if (pwr_upd) begin
        alast_q <= asgn;
        rlast_q <= rsgn;
      end
      egy_q  <= (egy_q & ~wclr[2*NP+6]) | egy_upd;
      corr_q <= (corr_q & ~wclr[2*NP+7]) | err_corr;
      fat_q  <= fat_q | err_fatal;
      if (bus_we && bus_addr) en_q <= bus_wdata[NM-1:0];
    end
  end

  assign status    = {fat_q, corr_q, egy_q, rflg_q, aflg_q, rev_q, pev_q};
  assign bus_rdata = bus_addr ? {{(DW-NM){1'b0}}, en_q} : {{(DW-SW){1'b0}}, status};
  assign irq       = (|(status[NM-1:0] & en_q)) | (|fat_q);

  AST_PULSE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (pev_q & ~$past(pev_q) & ~$past(fall)) == '0); // R2
  AST_REV_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q & ~$past(rev_q) & ~$past(fall)) == '0); // R3
  AST_PWR_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_upd) |-> (((aflg_q & ~$past(aflg_q)) | (rflg_q & ~$past(rflg_q))) == '0)); // R4
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fat_q & $past(fat_q)) == $past(fat_q)); // R9
  AST_IRQ_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
    (|fat_q) |-> irq); // R10
  AST_EGY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    egy_upd |=> egy_q); // R7
endmodule

// File: tb/test_mtr_flag_reg.sv
`timescale 1ns/1ps
module test_mtr_flag_reg;
  localparam int NP = 4, NF = 3, PW = 24, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pulse_pin = '0, pulse_neg = '0;
  logic pwr_upd = 0, sign_sel = 0, egy_upd = 0, err_corr = 0;
  logic [3*PW-1:0] act_tot = '0, act_fund = '0, rea_tot = '0, rea_fund = '0;
  logic [NF-1:0] err_fatal = '0;
  logic bus_we = 0, bus_addr = 0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq;

  always #2 clk = ~clk;

  mtr_flag_reg #(.NP(NP), .NF(NF), .PW(PW), .DW(DW)) i_mtr_flag_reg (
    .clk(clk), .rst_n(rst_n), .pulse_pin(pulse_pin), .pulse_neg(pulse_neg),
    .pwr_upd(pwr_upd), .sign_sel(sign_sel), .act_tot(act_tot), .act_fund(act_fund),
    .rea_tot(rea_tot), .rea_fund(rea_fund), .egy_upd(egy_upd), .err_fatal(err_fatal),
    .err_corr(err_corr), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit [3:0] m_pev, m_rev, m_plast, h1, h2, h3;
  bit [2:0] m_a, m_r, m_alast, m_rlast;
  bit m_egy, m_corr;
  bit [2:0] m_fat;
  bit [15:0] m_en;

  function automatic bit sgn(logic [3*PW-1:0] v, int p);
    return v[p*PW+PW-1];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pev = 0; m_rev = 0; m_plast = 0; h1 = 0; h2 = 0; h3 = 0;
      m_a = 0; m_r = 0; m_alast = 0; m_rlast = 0;
      m_egy = 0; m_corr = 0; m_fat = 0; m_en = 0;
    end else begin
      bit [31:0] clr;
      bit [3:0] f;
      clr = (bus_we && !bus_addr) ? bus_wdata : 32'h0;
      f = h3 & ~h2;
      m_pev = (m_pev & ~clr[3:0]) | f;
      for (int i = 0; i < NP; i++)
        if (f[i]) begin
          if (pulse_neg[i] != m_plast[i]) m_rev[i] = 1;
          else if (clr[4+i]) m_rev[i] = 0;
          m_plast[i] = pulse_neg[i];
        end else if (clr[4+i]) m_rev[i] = 0;
      for (int p = 0; p < 3; p++) begin
        bit sa, sr;
        sa = sign_sel ? sgn(act_fund, p) : sgn(act_tot, p);
        sr = sign_sel ? sgn(rea_fund, p) : sgn(rea_tot, p);
        if (clr[8+p]) m_a[p] = 0;
        if (clr[11+p]) m_r[p] = 0;
        if (pwr_upd) begin
          if (sa != m_alast[p]) m_a[p] = 1;
          if (sr != m_rlast[p]) m_r[p] = 1;
          m_alast[p] = sa; m_rlast[p] = sr;
        end
      end
      if (clr[14]) m_egy = 0;
      if (egy_upd) m_egy = 1;
      if (clr[15]) m_corr = 0;
      if (err_corr) m_corr = 1;
      m_fat = m_fat | err_fatal;
      if (bus_we && bus_addr) m_en = bus_wdata[15:0];
      h3 = h2; h2 = h1; h1 = pulse_pin;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    if (!done) begin
      if (!rst_n) begin
        chk("R1 status", bus_rdata, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
      end else if (!bus_addr) begin
        bit [15:0] ms;
        ms = {m_corr, m_egy, m_r, m_a, m_rev, m_pev};
        chk("R2/R8 pulse", {28'h0, bus_rdata[3:0]}, {28'h0, m_pev});
        chk("R3/R8 reversal", {28'h0, bus_rdata[7:4]}, {28'h0, m_rev});
        chk("R4/R6 active", {29'h0, bus_rdata[10:8]}, {29'h0, m_a});
        chk("R5/R6 reactive", {29'h0, bus_rdata[13:11]}, {29'h0, m_r});
        chk("R7 energy", {31'h0, bus_rdata[14]}, {31'h0, m_egy});
        chk("R9 errors", {28'h0, bus_rdata[18:15]}, {28'h0, m_fat, m_corr});
        chk("R11 upper zero", {13'h0, bus_rdata[31:19]}, 32'h0);
        chk("R10 irq", {31'h0, irq}, {31'h0, (|(ms & m_en)) | (|m_fat)});
      end else begin
        chk("R11 enable", bus_rdata, {16'h0, m_en});
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0; bus_addr = 0; bus_wdata = '0;
  endtask

  task automatic pulse(int i, bit neg);
    pulse_neg[i] = neg;
    tick();
    pulse_pin[i] = 1;
    tick(3);
    pulse_pin[i] = 0;
    tick(5);
  endtask

  task automatic setpwr(int p, bit at, bit af, bit rt, bit rf);
    act_tot[p*PW+:PW]  = at ? -24'sd1000 : 24'sd1000;
    act_fund[p*PW+:PW] = af ? -24'sd900 : 24'sd900;
    rea_tot[p*PW+:PW]  = rt ? -24'sd500 : 24'sd500;
    rea_fund[p*PW+:PW] = rf ? -24'sd400 : 24'sd400;
  endtask

  initial begin
    tick(4);
    rst_n = 1;
    tick(2);
    // R2/R3: first pulse positive, no reversal; then negative, reversal
    pulse(0, 0);
    pulse(0, 1);
    pulse(0, 1);
    pulse(1, 1);
    // rising edge held high: no new event until it falls
    wr(0, 32'hFF);
    pulse_pin[2] = 1; tick(6);
    pulse_pin[2] = 0; tick(5);
    // R8: write of zeros, then partial clear
    wr(0, 32'h0);
    wr(0, 32'h0000_0010);
    wr(0, 32'hFFFF_FFFF);
    // R8: clear landing on each cycle around a set
    for (int k = 0; k < 6; k++) begin
      pulse_neg[3] = ~pulse_neg[3];
      tick();
      pulse_pin[3] = 1; tick(2);
      pulse_pin[3] = 0;
      tick(k);
      wr(0, 32'h0000_0088);
      tick(4);
    end
    // R4/R5/R6: sign changes without strobe have no effect
    setpwr(0, 1, 0, 1, 0); setpwr(2, 0, 1, 0, 1);
    tick(3);
    pwr_upd = 1; tick(); pwr_upd = 0; tick(2);
    sign_sel = 1; tick(2);
    pwr_upd = 1; tick(); pwr_upd = 0; tick(2);
    wr(0, 32'h3F00);
    pwr_upd = 1; wr(0, 32'h3F00); pwr_upd = 0;
    sign_sel = 0; tick();
    // R7/R9/R10/R11
    egy_upd = 1; tick(); egy_upd = 0;
    wr(1, 32'hFFFF_4000);
    bus_addr = 1; tick(2); bus_addr = 0; tick(2);
    wr(0, 32'h4000); tick(2);
    err_corr = 1; tick(); err_corr = 0; tick(2);
    wr(1, 32'h0); tick(2);
    err_fatal = 3'b010; tick(); err_fatal = 0; tick(2);
    wr(0, 32'hFFFF_FFFF); tick(2);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 3) == 0) pulse_pin = 4'($urandom);
      if ($urandom_range(0, 5) == 0) pulse_neg = 4'($urandom);
      for (int p = 0; p < 3; p++)
        if ($urandom_range(0, 7) == 0)
          setpwr(p, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      sign_sel  = ($urandom_range(0, 15) == 0) ? ~sign_sel : sign_sel;
      pwr_upd   = ($urandom_range(0, 9) == 0);
      egy_upd   = ($urandom_range(0, 19) == 0);
      err_corr  = ($urandom_range(0, 49) == 0);
      err_fatal = ($urandom_range(0, 499) == 0) ? 3'(1 << $urandom_range(0, 2)) : 3'b0;
      bus_we    = ($urandom_range(0, 5) == 0);
      bus_addr  = ($urandom_range(0, 7) == 0);
      bus_wdata = $urandom;
      tick();
    end
    pwr_upd = 0; egy_upd = 0; err_corr = 0; err_fatal = 0; bus_we = 0; bus_addr = 0;
    tick(4);
    // R1: reset clears everything including fatal bits
    rst_n = 0; tick(3); rst_n = 1; tick(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule